// File: doc/BRIEF.md
# Key-Unlocked Protected Register Guard

This block is a small system-control register file in which some registers cannot be changed by an ordinary write. Software must first write a fixed unlock key to a lock register. The very next write may then target one protected register, and that write takes effect. Every protected write uses up the unlock, whether or not it was accepted, so each change needs its own key. Any other write in between also cancels the unlock. A write that reaches a protected register while the block is locked is dropped, and a sticky flag records that it happened.

Two registers are protected. The first is a device-configuration word. Its top bit requests a software reset, and its remaining bits are pin-selection settings for downstream logic. The second is a clock-divider word. Software changes the configuration word by read-modify-write: it reads the word, edits the bits, writes the key, then writes the word back.

A software reset is requested by setting the reset bit and then clearing it in a later write. The block turns the clearing edge into a single-cycle pulse on its reset-request output. A scratch register and a status register take ordinary writes. The register bus is 32 bits wide and word addressed. Reads are returned one cycle after the access.

Top module: `prot_reg_guard`

## Requirements
- R1: After a synchronous active-low reset the block is locked. The configuration word equals CFG_INIT (default 0). The divider word equals DIV_INIT (default 4). Scratch, the violation flag, reset_req and bus_rdata are all 0.
- R2: A write of 32'h0000_00AA to the lock register (address 0) unlocks the block. A write of any other value to address 0 locks it. A read of address 0 returns 1 while unlocked and 0 while locked. A second key write leaves the block unlocked.
- R3: While the block is unlocked, a write to the configuration word (address 1) or the divider word (address 2) stores the written data. The new value appears on cfg_out or clkdiv_out the cycle after the write.
- R4: A write to address 1 or 2 while the block is locked leaves that register unchanged. It also sets the violation flag, which is bit 0 of the status register (address 4).
- R5: Any write to address 1 or 2, accepted or not, locks the block. A further protected write without a new key is ignored.
- R6: A write to any address other than 0, 1 or 2 cancels an unlock. This includes scratch, status and unmapped addresses.
- R7: Reads at any address leave the lock state unchanged.
- R8: reset_req is high for exactly one cycle, the cycle after an accepted write to address 1 that clears bit 31 while bit 31 was set. Setting bit 31, rewriting it as 0 when it is already 0, or attempting the clear while locked gives no pulse.
- R9: The scratch register (address 3) takes any write at any lock state.
- R10: The violation flag stays set until a status write with bit 0 equal to 1 clears it. A status write with bit 0 equal to 0 leaves it set.
- R11: A read returns the addressed register on bus_rdata one cycle after the access. Unmapped addresses (5 to 7) read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| cfg_out | output | 32 | Current device-configuration word |
| clkdiv_out | output | 32 | Current clock-divider word |
| reset_req | output | 1 | One-cycle software-reset request |

## Verification
Every result is due one clock edge after its access: the register value, the lock state, the violation flag, the read data and the reset pulse. The bench drives each access on a falling edge and samples at the next falling edge. At that point exactly one rising edge has registered the access. A reset pulse is checked at that falling edge, and its absence is checked one idle cycle later. A write that the design drops is observed by reading the register back through the bus and checking cfg_out or clkdiv_out directly.

// File: rtl/pgr_pkg.sv
// Package: shared constants and types of the protected register guard.
// Assumes word addressing with the key register at index 0, followed
// directly by the protected registers.
package pgr_pkg;
    localparam logic [31:0] UNLOCK_KEY = 32'h0000_00AA;
    localparam int unsigned NPROT      = 2;
    localparam int unsigned IDX_KEY    = 0;
    localparam int unsigned IDX_CFG    = 1;
    localparam int unsigned IDX_DIV    = 2;
    localparam int unsigned IDX_SCR    = 3;
    localparam int unsigned IDX_STAT   = 4;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_KEY  = 2'd1,
        ACC_PROT = 2'd2,
        ACC_OPEN = 2'd3
    } acc_kind_t;
endpackage

// File: rtl/pgr_decode.sv
// Module: pgr_decode
// Classifies the current bus access as a key write, a protected write,
// an unprotected write or no write. It also gives a one-hot select over
// the protected registers. Purely combinational.
module pgr_decode #(
    parameter int ADDR_W = 3
) (
    input  logic                       sel,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    output pgr_pkg::acc_kind_t         kind,
    output logic [pgr_pkg::NPROT-1:0]  prot_hit
);
    import pgr_pkg::*;

    logic is_write;
    assign is_write = sel && wr;

    // One select line per protected register.
    for (genvar g = 0; g < int'(NPROT); g++) begin : g_hit
        assign prot_hit[g] = is_write && (addr == ADDR_W'(IDX_CFG + g));
    end

    // Sort the access into the kinds the key gate cares about.
    always_comb begin
        if (!is_write)                    kind = ACC_NONE;
        else if (addr == ADDR_W'(IDX_KEY)) kind = ACC_KEY;
        else if (|prot_hit)               kind = ACC_PROT;
        else                              kind = ACC_OPEN;
    end
endmodule

// File: rtl/pgr_key_gate.sv
// Module: pgr_key_gate
// Holds the single-use unlock state. A key write arms it. Any other
// write disarms it. A protected write is accepted only when it is armed.
// Assumes at most one access per cycle.
module pgr_key_gate (
    input  logic               clk,
    input  logic               rst_n,
    input  pgr_pkg::acc_kind_t kind,
    input  logic [31:0]        wdata,
    output logic               unlocked,
    output logic               accept,
    output logic               violation
);
    import pgr_pkg::*;

    // Arm on the exact key, disarm on every other write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   unlocked <= 1'b0;
        else if (kind == ACC_KEY)                     unlocked <= (wdata == UNLOCK_KEY);
        else if (kind == ACC_PROT || kind == ACC_OPEN) unlocked <= 1'b0;
    end

    // Decide the fate of a protected write from the armed state.
    assign accept    = (kind == ACC_PROT) &&  unlocked;
    assign violation = (kind == ACC_PROT) && !unlocked;
endmodule

// File: rtl/pgr_prot_reg.sv
// Module: pgr_prot_reg
// One protected 32-bit storage word. It loads only on an accepted write.
// Assumes the key gate has already qualified the write enable.
module pgr_prot_reg #(
    parameter logic [31:0] INIT = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] d,
    output logic [31:0] q
);
    // Load the word on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= INIT;
        else if (we) q <= d;
    end
endmodule

// File: rtl/pgr_reset_pulse.sv
// Module: pgr_reset_pulse
// Turns an accepted write that takes the reset bit from 1 to 0 into a
// registered one-cycle request. Assumes two accepted writes cannot be
// back to back, which holds because each one needs a fresh key.
module pgr_reset_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic cur_bit,
    input  logic new_bit,
    output logic pulse
);
    // Register the falling edge of the reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= we && cur_bit && !new_bit;
    end
endmodule

// File: rtl/prot_reg_guard.sv
// Module: prot_reg_guard (top)
// System-control register file. Index 0 is the key register. Indices 1
// and 2 are the protected configuration and divider words. Index 3 is
// scratch. Index 4 is status, with the sticky violation flag in bit 0,
// cleared by writing 1. Reads are registered.
// Assumes ADDR_W >= 3 and at most one access per cycle.
module prot_reg_guard #(
    parameter int          ADDR_W    = 3,
    parameter int          SRST_BIT  = 31,
    parameter logic [31:0] CFG_INIT  = 32'h0000_0000,
    parameter logic [31:0] DIV_INIT  = 32'h0000_0004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       cfg_out,
    output logic [31:0]       clkdiv_out,
    output logic              reset_req
);
    import pgr_pkg::*;

    acc_kind_t          kind;
    logic [NPROT-1:0]   prot_hit;
    logic               unlocked;
    logic               accept;
    logic               viol_set;
    logic               viol_q;
    logic [31:0]        scratch_q;
    logic [31:0]        prot_q [NPROT];
    logic [31:0]        rd_mux;

    pgr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel      (bus_sel),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .kind     (kind),
        .prot_hit (prot_hit)
    );

    pgr_key_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .wdata     (bus_wdata),
        .unlocked  (unlocked),
        .accept    (accept),
        .violation (viol_set)
    );

    // One storage word per protected register; the first is configuration.
    for (genvar g = 0; g < int'(NPROT); g++) begin : g_prot
        pgr_prot_reg #(.INIT((g == 0) ? CFG_INIT : DIV_INIT)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (accept && prot_hit[g]),
            .d     (bus_wdata),
            .q     (prot_q[g])
        );
    end

    assign cfg_out    = prot_q[IDX_CFG - 1];
    assign clkdiv_out = prot_q[IDX_DIV - 1];

    pgr_reset_pulse u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (accept && prot_hit[IDX_CFG - 1]),
        .cur_bit (cfg_out[SRST_BIT]),
        .new_bit (bus_wdata[SRST_BIT]),
        .pulse   (reset_req)
    );

    // Scratch word: ordinary write at any lock state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scratch_q <= '0;
        else if (kind == ACC_OPEN && bus_addr == ADDR_W'(IDX_SCR))
            scratch_q <= bus_wdata;
    end

    // Sticky violation flag: set by a locked protected write, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            viol_q <= 1'b0;
        else if (viol_set)
            viol_q <= 1'b1;
        else if (kind == ACC_OPEN && bus_addr == ADDR_W'(IDX_STAT) && bus_wdata[0])
            viol_q <= 1'b0;
    end

    // Select the read value for the addressed word.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(IDX_KEY))       rd_mux = {31'b0, unlocked};
        else if (bus_addr == ADDR_W'(IDX_CFG))  rd_mux = cfg_out;
        else if (bus_addr == ADDR_W'(IDX_DIV))  rd_mux = clkdiv_out;
        else if (bus_addr == ADDR_W'(IDX_SCR))  rd_mux = scratch_q;
        else if (bus_addr == ADDR_W'(IDX_STAT)) rd_mux = {31'b0, viol_q};
    end

    // Register read data on a read access; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/prot_reg_guard_chk.sv
// Module: prot_reg_guard_chk
// Property checker bound into prot_reg_guard. It observes the bus, the
// unlock state, the violation flag and the outputs.
module prot_reg_guard_chk #(
    parameter int ADDR_W   = 3,
    parameter int SRST_BIT = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              unlocked,
    input logic              viol_q,
    input logic [31:0]       cfg_out,
    input logic              reset_req
);
    logic wr_any, wr_key, wr_prot, wr_open, wr_cfg, clr_stat;
    assign wr_any   = bus_sel && bus_wr;
    assign wr_key   = wr_any && bus_addr == ADDR_W'(0);
    assign wr_cfg   = wr_any && bus_addr == ADDR_W'(1);
    assign wr_prot  = wr_cfg || (wr_any && bus_addr == ADDR_W'(2));
    assign wr_open  = wr_any && !wr_key && !wr_prot;
    assign clr_stat = wr_any && bus_addr == ADDR_W'(4) && bus_wdata[0];

    a_r2_key_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_key && bus_wdata == 32'h0000_00AA) |=> unlocked);
    a_r2_bad_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_key && bus_wdata != 32'h0000_00AA) |=> !unlocked);
    a_r4_locked_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !unlocked) |=> $stable(cfg_out));
    a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prot |=> !unlocked);
    a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        wr_open |=> !unlocked);
    a_r7_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_any) |=> $stable(unlocked));
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_q && !clr_stat) |=> viol_q);
    a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
    a_r8_falling: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> (!cfg_out[SRST_BIT] && $past(cfg_out[SRST_BIT])));
endmodule

bind prot_reg_guard prot_reg_guard_chk #(.ADDR_W(ADDR_W), .SRST_BIT(SRST_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .unlocked  (unlocked),
    .viol_q    (viol_q),
    .cfg_out   (cfg_out),
    .reset_req (reset_req)
);

// File: tb/tb_prot_reg_guard.sv
// Bench: vector table walk, then directed reset and corner tests.
module tb_prot_reg_guard;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata, cfg_out, clkdiv_out;
    logic          reset_req;

    int n_tests = 0;
    int n_fail  = 0;

    prot_reg_guard dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_out(cfg_out), .clkdiv_out(clkdiv_out), .reset_req(reset_req)
    );

    always #(2.5ns) clk = ~clk;

    // Vector: {req[3:0], write, addr[2:0], data[31:0], expected[31:0]}
    localparam int NV = 18;
    localparam logic [71:0] VEC [NV] = '{
        {4'd2, 1'b1, 3'd0, 32'h0000_00AA, 32'h0},            // R2 unlock
        {4'd3, 1'b1, 3'd1, 32'h0000_00F0, 32'h0},            // R3 cfg write
        {4'd3, 1'b0, 3'd1, 32'h0,         32'h0000_00F0},    // R3 cfg stored
        {4'd5, 1'b0, 3'd0, 32'h0,         32'h0},            // R5 relocked
        {4'd4, 1'b1, 3'd1, 32'h0000_0123, 32'h0},            // R4 locked write
        {4'd4, 1'b0, 3'd1, 32'h0,         32'h0000_00F0},    // R4 unchanged
        {4'd4, 1'b0, 3'd4, 32'h0,         32'h0000_0001},    // R4 flag set
        {4'd2, 1'b1, 3'd0, 32'h0000_00AA, 32'h0},            // R2 unlock
        {4'd7, 1'b0, 3'd0, 32'h0,         32'h0000_0001},    // R7 read keeps unlock
        {4'd3, 1'b1, 3'd2, 32'h0000_0010, 32'h0},            // R3 divider write
        {4'd3, 1'b0, 3'd2, 32'h0,         32'h0000_0010},    // R3 divider stored
        {4'd2, 1'b1, 3'd0, 32'h0000_0055, 32'h0},            // R2 wrong key
        {4'd2, 1'b0, 3'd0, 32'h0,         32'h0},            // R2 still locked
        {4'd2, 1'b1, 3'd0, 32'h0000_00AA, 32'h0},            // R2 unlock
        {4'd9, 1'b1, 3'd3, 32'h0000_DEAD, 32'h0},            // R9 scratch write
        {4'd6, 1'b1, 3'd2, 32'h0000_0099, 32'h0},            // R6 cancelled
        {4'd6, 1'b0, 3'd2, 32'h0,         32'h0000_0010},    // R6 divider unchanged
        {4'd9, 1'b0, 3'd3, 32'h0,         32'h0000_DEAD}     // R9 scratch stored
    };

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Each access takes one cycle: drive after a falling edge, release at the next.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(500us);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(1, "rdata after reset", bus_rdata, 32'h0);
        chk(1, "reset_req after reset", {31'b0, reset_req}, 32'h0);
        chk(1, "cfg_out after reset", cfg_out, 32'h0);
        chk(1, "clkdiv_out after reset", clkdiv_out, 32'h4);
        rd(3'd0, v); chk(1, "locked after reset", v, 32'h0);
        rd(3'd4, v); chk(1, "flag clear after reset", v, 32'h0);
        rd(3'd3, v); chk(1, "scratch after reset", v, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][67]) wr(VEC[i][66:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][66:64], v);
                chk(int'(VEC[i][71:68]), $sformatf("vector %0d", i), v, VEC[i][31:0]);
            end
        end
        chk(3, "clkdiv_out port", clkdiv_out, 32'h10);

        // R10 clearing rule
        wr(3'd4, 32'h0); rd(3'd4, v); chk(10, "write 0 keeps flag", v, 32'h1);
        wr(3'd4, 32'h1); rd(3'd4, v); chk(10, "write 1 clears flag", v, 32'h0);

        // R6 status write cancels unlock
        wr(3'd0, 32'hAA); wr(3'd4, 32'h0); wr(3'd1, 32'h1);
        rd(3'd1, v); chk(6, "status write cancels", v, 32'hF0);
        rd(3'd4, v); chk(4, "flag from cancelled write", v, 32'h1);
        wr(3'd4, 32'h1);
        // R6 unmapped write cancels unlock
        wr(3'd0, 32'hAA); wr(3'd7, 32'h5); wr(3'd2, 32'h77);
        chk(6, "unmapped write cancels", clkdiv_out, 32'h10);
        // R11 unmapped read
        rd(3'd6, v); chk(11, "unmapped read", v, 32'h0);
        // R2 double key, then R5 second write without key
        wr(3'd0, 32'hAA); wr(3'd0, 32'hAA); wr(3'd2, 32'h22);
        chk(2, "double key accepted", clkdiv_out, 32'h22);
        wr(3'd2, 32'h33);
        chk(5, "second write needs key", clkdiv_out, 32'h22);
        wr(3'd4, 32'h1);

        // R8 reset request sequences
        wr(3'd0, 32'hAA); wr(3'd1, 32'h8000_00F0);
        chk(8, "no pulse on set", {31'b0, reset_req}, 32'h0);
        chk(3, "cfg_out set bit", cfg_out, 32'h8000_00F0);
        wr(3'd0, 32'hAA); wr(3'd1, 32'h0000_00F0);
        chk(8, "pulse on clear", {31'b0, reset_req}, 32'h1);
        @(negedge clk);
        chk(8, "pulse one cycle", {31'b0, reset_req}, 32'h0);
        wr(3'd0, 32'hAA); wr(3'd1, 32'h0000_00F0);
        chk(8, "no pulse when already 0", {31'b0, reset_req}, 32'h0);
        wr(3'd0, 32'hAA); wr(3'd1, 32'h8000_00F0);
        wr(3'd1, 32'h0000_00F0);
        chk(8, "no pulse on locked clear", {31'b0, reset_req}, 32'h0);
        chk(4, "locked clear ignored", cfg_out, 32'h8000_00F0);
        @(negedge clk);
        chk(8, "still no pulse", {31'b0, reset_req}, 32'h0);

        summary();
    end
endmodule